// File: doc/BRIEF.md
# First-Order Delta-Sigma Pulse Distributor

This block turns a K-bit unsigned level code into a single registered output bit. Over a full cycle the fraction of clocks on which that bit is 1 equals the code divided by the cycle modulus. The ones are spread as evenly as the modulus allows instead of being grouped at the start of the cycle. The ripple therefore sits at high frequencies, where a slow external RC low-pass can remove it. With K = 20 and a 1 MHz clock, one full cycle lasts about a second.

On each enabled clock the code is added into a K-bit accumulator. The carry out of that addition is the output bit, so taking the modulus off the accumulator costs nothing: the overflow is simply dropped. A static parameter selects carry-feedback mode. In that mode each carry is added back as a carry-in on the next addition. The modulus becomes 2^K−1, and both a constant 0 and a constant 1 can be reached without widening the code. The code may change on any clock. The change applies to the next addition and leaves the accumulator alone, so a code change causes no glitch.

Control is a three-mode decode of reset and enable. CLEAR (reset high) zeroes the accumulator, the carry and the output. HOLD (reset low, enable low) freezes the accumulator and the carry and drives the output low. RUN (reset low, enable high) performs the addition. Each clock edge takes the mode decoded from that cycle's inputs, so any of the three modes can follow any other.

Top module: `dsm_pulse_spread`

## Requirements
- R1: On a clock edge with `rst` high, the accumulator, the carry and `pulse_out` go to 0. This takes priority over `en`. The first enabled clock after reset then behaves as if the accumulator starts from zero.
- R2: On each clock edge with `rst` low and `en` high, the block computes acc + level (+ the stored carry in feedback mode) as a (K+1)-bit sum. The low K bits go into the accumulator. Bit K appears on `pulse_out` after that same edge.
- R3: With `CARRY_FB` = 0, every run of 2^K consecutive enabled clocks at a constant code V contains exactly V ones. A code of 0 never produces a 1.
- R4: With `CARRY_FB` = 1, the modulus is 2^K−1. At a constant code V, every run of 2^K−1 consecutive enabled clocks contains between V−1 and V+1 ones. After reset, the run that starts at the second enabled clock contains exactly V ones.
- R5: With `CARRY_FB` = 1, a code of 0 applied from reset gives a constant 0. A code of all ones gives 1 on every enabled clock after the first.
- R6: With `CARRY_FB` = 0 and code 2^(K−2) applied from reset, `pulse_out` is 1 on exactly every fourth enabled clock: the 4th, the 8th, and so on.
- R7: On a clock edge with `rst` low and `en` low, `pulse_out` goes to 0 and the accumulator and the carry keep their values. When enable returns, the output sequence continues as if the paused clocks had not occurred.
- R8: A new code takes effect on the next enabled clock without clearing the accumulator. The output follows the R2 recurrence continuously across the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable; when low the accumulator holds and the output is 0 |
| level | input | K | Unsigned level code V |
| pulse_out | output | 1 | Registered pulse-density output |

## Verification
One plain-modulus instance and one carry-feedback instance receive the same stimulus, and every clock is compared against a cycle-exact model of the add-and-wrap recurrence.

The tests use the following code patterns:
- **Sparse, odd, near-half and near-full codes:** distinguish the moduli 2^K and 2^K−1 by the count of ones per window.
- **Quarter-scale code:** reveals any clumping of ones in place of even spacing.
- **All zeros and all ones:** exercise the carry-feedback extremes.
- **Pauses and code changes in mid-cycle:** separate an accumulator that holds or continues from one that is cleared or reloaded.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    // Operating mode decoded from reset and enable each cycle
    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_RUN   = 2'd2
    } dsm_mode_e;

endpackage

// File: rtl/dsm_ctrl.sv
module dsm_ctrl
    import dsm_pkg::*;
(
    input  logic      rst,
    input  logic      en,
    output dsm_mode_e mode
);

    // Reset outranks enable (R1); enable low selects HOLD (R7)
    always_comb begin
        mode = MODE_HOLD;
        unique casez ({rst, en})
            2'b1?:   mode = MODE_CLEAR;
            2'b01:   mode = MODE_RUN;
            2'b00:   mode = MODE_HOLD;
            default: mode = MODE_HOLD;
        endcase
    end

endmodule

// File: rtl/dsm_accum.sv
module dsm_accum
    import dsm_pkg::*;
#(
    parameter int K        = 20,
    parameter bit CARRY_FB = 1'b0
) (
    input  logic         clk,
    input  dsm_mode_e    mode,
    input  logic [K-1:0] level,
    output logic [K-1:0] acc_q,
    output logic         carry_next
);

    localparam int SW = K + 1;

    logic          cin;
    logic [SW-1:0] sum;

    generate
        if (CARRY_FB) begin : g_fb
            // Stored carry re-enters the next addition: modulus 2^K-1
            logic carry_q;
            always_ff @(posedge clk) begin
                unique case (mode)
                    MODE_CLEAR: carry_q <= 1'b0;
                    MODE_HOLD:  carry_q <= carry_q;
                    MODE_RUN:   carry_q <= sum[K];
                    default:    carry_q <= 1'b0;
                endcase
            end
            assign cin = carry_q;
        end else begin : g_plain
            // Overflow is simply dropped: modulus 2^K
            assign cin = 1'b0;
        end
    endgenerate

    assign sum        = {1'b0, acc_q} + {1'b0, level} + {{K{1'b0}}, cin};
    assign carry_next = sum[K];

    always_ff @(posedge clk) begin
        unique case (mode)
            MODE_CLEAR: acc_q <= '0;
            MODE_HOLD:  acc_q <= acc_q;
            MODE_RUN:   acc_q <= sum[K-1:0];
            default:    acc_q <= '0;
        endcase
    end

endmodule

// File: rtl/dsm_outreg.sv
module dsm_outreg
    import dsm_pkg::*;
(
    input  logic      clk,
    input  dsm_mode_e mode,
    input  logic      carry_next,
    output logic      pulse_q
);

    always_ff @(posedge clk) begin
        unique case (mode)
            MODE_CLEAR: pulse_q <= 1'b0;
            MODE_HOLD:  pulse_q <= 1'b0;
            MODE_RUN:   pulse_q <= carry_next;
            default:    pulse_q <= 1'b0;
        endcase
    end

endmodule

// File: rtl/dsm_pulse_spread.sv
module dsm_pulse_spread
    import dsm_pkg::*;
#(
    parameter int K        = 20,
    parameter bit CARRY_FB = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [K-1:0] level,
    output logic         pulse_out
);

    dsm_mode_e    mode;
    logic [K-1:0] acc_q;
    logic         carry_next;

    dsm_ctrl u_ctrl (
        .rst  (rst),
        .en   (en),
        .mode (mode)
    );

    dsm_accum #(.K(K), .CARRY_FB(CARRY_FB)) u_accum (
        .clk        (clk),
        .mode       (mode),
        .level      (level),
        .acc_q      (acc_q),
        .carry_next (carry_next)
    );

    dsm_outreg u_out (
        .clk        (clk),
        .mode       (mode),
        .carry_next (carry_next),
        .pulse_q    (pulse_out)
    );

endmodule

// File: rtl/dsm_pulse_spread_chk.sv
module dsm_pulse_spread_chk #(
    parameter int K        = 20,
    parameter bit CARRY_FB = 1'b0
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic [K-1:0] level,
    input logic         pulse_out,
    input logic [K-1:0] acc_q
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (pulse_out == 1'b0 && acc_q == '0));

    assert_idle_low_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pulse_out);

    assert_hold_acc_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc_q));

    generate
        if (!CARRY_FB) begin : g_plain
            assert_zero_code_R3: assert property (@(posedge clk) disable iff (rst)
                (en && level == '0) |=> !pulse_out);
        end else begin : g_fb
            assert_full_on_R5: assert property (@(posedge clk) disable iff (rst)
                (en && &level && $past(en) && &($past(level)) && !$past(rst))
                |=> pulse_out);
        end
    endgenerate

endmodule

bind dsm_pulse_spread dsm_pulse_spread_chk #(.K(K), .CARRY_FB(CARRY_FB)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .level     (level),
    .pulse_out (pulse_out),
    .acc_q     (acc_q)
);

// File: tb/test_dsm_pulse_spread.sv
module test_dsm_pulse_spread;

    localparam int K = 6;
    localparam int N = 1 << K;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic [K-1:0] level = '0;
    logic         q0, q1;

    int n_cmp = 0;
    int n_bad = 0;
    int a0 = 0;
    int a1 = 0;
    logic e0 = 1'b0;
    logic e1 = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dsm_pulse_spread #(.K(K), .CARRY_FB(1'b0)) i_dsm_pulse_spread (
        .clk(clk), .rst(rst), .en(en), .level(level), .pulse_out(q0));

    dsm_pulse_spread #(.K(K), .CARRY_FB(1'b1)) i_dsm_pulse_spread_fb (
        .clk(clk), .rst(rst), .en(en), .level(level), .pulse_out(q1));

    task automatic check_bit(string tag, string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic check_int(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Called at a falling edge; applies inputs, updates the model at the
    // rising edge and compares both outputs at the next falling edge.
    task automatic step(string tag, bit r, bit e, int v);
        rst   = r;
        en    = e;
        level = v[K-1:0];
        @(posedge clk);
        if (r) begin
            a0 = 0; a1 = 0; e0 = 1'b0; e1 = 1'b0;
        end else if (!e) begin
            e0 = 1'b0; e1 = 1'b0;
        end else begin
            int s;
            s = a0 + v;
            e0 = (s >= N);
            if (e0) s -= N;
            a0 = s;
            s = a1 + v;
            e1 = (s >= N);
            if (e1) s -= N - 1;
            a1 = s;
        end
        @(negedge clk);
        check_bit(tag, "plain", q0, e0);
        check_bit(tag, "feedback", q1, e1);
    endtask

    task automatic do_reset();
        step("R1", 1'b1, 1'b1, N - 1);
        step("R1", 1'b1, 1'b0, 0);
    endtask

    task automatic t_reset();
        do_reset();
        check_bit("R1", "plain after reset", q0, 1'b0);
        check_bit("R1", "feedback after reset", q1, 1'b0);
        step("R1", 1'b0, 1'b1, 1);
        check_bit("R1", "first enabled clock from zero", q0, 1'b0);
    endtask

    task automatic t_window_plain(int v);
        int cnt = 0;
        do_reset();
        for (int i = 0; i < N; i++) step("R2", 1'b0, 1'b1, v);
        for (int i = 0; i < N; i++) begin
            step("R2", 1'b0, 1'b1, v);
            cnt += q0;
        end
        check_int("R3", "ones per 2^K window", cnt, v);
    endtask

    task automatic t_window_fb(int v);
        int cnt = 0;
        int diff;
        do_reset();
        step("R2", 1'b0, 1'b1, v);
        for (int i = 0; i < N - 1; i++) begin
            step("R4", 1'b0, 1'b1, v);
            cnt += q1;
        end
        check_int("R4", "ones per 2^K-1 window after reset", cnt, v);
        cnt = 0;
        for (int i = 0; i < 7; i++) step("R4", 1'b0, 1'b1, v);
        for (int i = 0; i < N - 1; i++) begin
            step("R4", 1'b0, 1'b1, v);
            cnt += q1;
        end
        diff = cnt - v;
        check_int("R4", "offset window within one", (diff >= -1 && diff <= 1) ? 1 : 0, 1);
    endtask

    task automatic t_extremes();
        int cnt = 0;
        do_reset();
        for (int i = 0; i < N; i++) begin
            step("R5", 1'b0, 1'b1, 0);
            cnt += q1;
        end
        check_int("R5", "zero code ones", cnt, 0);
        do_reset();
        step("R5", 1'b0, 1'b1, N - 1);
        check_bit("R5", "first full-code clock", q1, 1'b0);
        cnt = 0;
        for (int i = 0; i < N; i++) begin
            step("R5", 1'b0, 1'b1, N - 1);
            cnt += q1;
        end
        check_int("R5", "full code ones", cnt, N);
    endtask

    task automatic t_spread();
        do_reset();
        for (int i = 1; i <= 32; i++) begin
            step("R6", 1'b0, 1'b1, N / 4);
            check_bit("R6", "quarter spacing", q0, (i % 4) == 0);
        end
    endtask

    task automatic t_pause();
        do_reset();
        for (int i = 0; i < 10; i++) step("R7", 1'b0, 1'b1, 23);
        for (int i = 0; i < 5; i++) begin
            step("R7", 1'b0, 1'b0, 23);
            check_bit("R7", "paused output", q0 | q1, 1'b0);
        end
        for (int i = 0; i < 40; i++) step("R7", 1'b0, 1'b1, 23);
    endtask

    task automatic t_change();
        do_reset();
        for (int i = 0; i < 20; i++) step("R8", 1'b0, 1'b1, 10);
        for (int i = 0; i < 20; i++) step("R8", 1'b0, 1'b1, 50);
        for (int i = 0; i < 20; i++) step("R8", 1'b0, 1'b1, 3);
        for (int i = 0; i < 20; i++) step("R8", 1'b0, 1'b1, N - 1);
        for (int i = 0; i < 10; i++) step("R8", 1'b0, 1'b1, 0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_window_plain(1);
        t_window_plain(5);
        t_window_plain(37);
        t_window_plain(N - 1);
        t_window_fb(1);
        t_window_fb(5);
        t_window_fb(37);
        t_window_fb(N - 2);
        t_extremes();
        t_spread();
        t_pause();
        t_change();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule